// File: doc/BRIEF.md
# Supply Undervoltage Reset Generator with Input Gating

This block turns a pair of supply comparator flags into a clean active-low system reset and holds the user control inputs at safe values while that reset is low. A low-threshold flag (`uvDet`) must stay set for a filter time before reset is pulled low, so short glitches on the supply are ignored. A separate higher-threshold flag (`uvOk`) must then stay set without a break for a much longer hold time before reset is let go. The mode controller can also hold reset low directly, for example while the part is powered down or asleep.

While reset is low, the three high-side switch requests are treated as low, so every switch is off. The bus pass-through switch falls back to its closed state, which lets bus traffic pass. The same fallback applies while the overtemperature flag is set. When reset is high, each high-side enable follows its request and the bus switch opens when its disable input is high.

Both time windows are counted in clock cycles and set by parameters: `DET_CYCLES` for the detection filter and `RCV_CYCLES` for the recovery hold. The defaults suit a 125 MHz clock, giving about 8 µs and 4 ms.

Top module: `uvr_top`

## Requirements
- R1: While `arstN` is low, `sysRstN` is 0, every bit of `hsEn` is 0 and `busClose` is 1.
- R2: When `sysRstN` is high, `uvDet` sampled high on `DET_CYCLES` consecutive clock edges drives `sysRstN` low right after the last of those edges.
- R3: A `uvDet` pulse sampled high on fewer than `DET_CYCLES` consecutive edges leaves `sysRstN` high.
- R4: When `sysRstN` is low, it goes high right after the edge on which `uvOk` has been sampled high, with `forceRst` low, on `RCV_CYCLES` consecutive edges.
- R5: One edge with `uvOk` low during the recovery count restarts the count from zero, so a full `RCV_CYCLES` run of high samples is needed after that edge.
- R6: `forceRst` sampled high drives `sysRstN` low after that edge and keeps it low. The recovery count starts only on the first edge with `forceRst` low.
- R7: While `sysRstN` is high, `hsEn[i]` equals `hsReq[i]` for each channel i.
- R8: While `sysRstN` is low, `hsEn` is all zeros, whatever `hsReq` is.
- R9: While `sysRstN` is high and `overTemp` is low, `busClose` is the inverse of `busOff` (1 means the bus switch is closed).
- R10: While `sysRstN` is low or `overTemp` is high, `busClose` is 1, whatever `busOff` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arstN | input | 1 | Asynchronous active-low block reset |
| uvDet | input | 1 | Supply below the detection threshold |
| uvOk | input | 1 | Supply above the higher recovery threshold |
| forceRst | input | 1 | Mode controller demands reset (off or sleep) |
| overTemp | input | 1 | Overtemperature protection active |
| hsReq | input | NUM_HS | High-side switch requests, active high |
| busOff | input | 1 | Bus switch open request, active high |
| sysRstN | output | 1 | System reset, active low |
| hsEn | output | NUM_HS | Gated high-side switch enables |
| busClose | output | 1 | Gated bus switch close command |

## Verification
The checker looks at every cycle. It checks that the gated outputs take their safe values whenever reset is low or overtemperature is set, and that they follow their inputs when reset is high. It checks that a forced reset always gives a low reset on the next cycle, that every rise of reset follows a cycle with the recovery flag high and no force, and that every fall not caused by a force follows a full run of detection samples. The exact lengths of the two windows can only be shown by the bench scenarios. These cover the boundary one edge short of each window, a detection pulse one edge too short, and a recovery count restarted by a single dropped sample or held off by a forced reset.

// File: rtl/uvr_pkg.sv
package uvr_pkg;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } rstState_e;

  typedef struct packed {
    logic detInc;
    logic detClr;
    logic rcvInc;
    logic rcvClr;
  } cntStrobe_t;

endpackage

// File: rtl/uvr_datapath.sv
module uvr_datapath
  import uvr_pkg::*;
#(
  parameter int DET_CYCLES = 1000,
  parameter int RCV_CYCLES = 500000,
  parameter int NUM_HS     = 3
) (
  input  logic              clk,
  input  logic              arstN,
  input  cntStrobe_t        strobe,
  input  logic              sysRstN,
  input  logic              overTemp,
  input  logic [NUM_HS-1:0] hsReq,
  input  logic              busOff,
  output logic              detDone,
  output logic              rcvDone,
  output logic [NUM_HS-1:0] hsEn,
  output logic              busClose
);

  localparam int DET_W = $clog2(DET_CYCLES + 1);
  localparam int RCV_W = $clog2(RCV_CYCLES + 1);
  localparam logic [DET_W-1:0] DET_LAST = DET_W'(DET_CYCLES - 1);
  localparam logic [RCV_W-1:0] RCV_LAST = RCV_W'(RCV_CYCLES - 1);

  logic [DET_W-1:0] detCnt;
  logic [RCV_W-1:0] rcvCnt;

  // detection filter counter
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)             detCnt <= '0;
    else if (strobe.detClr) detCnt <= '0;
    else if (strobe.detInc) detCnt <= detCnt + 1'b1;
  end

  // recovery hold counter
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)             rcvCnt <= '0;
    else if (strobe.rcvClr) rcvCnt <= '0;
    else if (strobe.rcvInc) rcvCnt <= rcvCnt + 1'b1;
  end

  assign detDone = (detCnt == DET_LAST);
  assign rcvDone = (rcvCnt == RCV_LAST);

  // per-channel gating of the high-side requests
  for (genvar g = 0; g < NUM_HS; g++) begin : gHsGate
    assign hsEn[g] = sysRstN & hsReq[g];
  end

  // bus switch falls back to closed when its input is ignored
  always_comb begin
    if (sysRstN && !overTemp) busClose = ~busOff;
    else                      busClose = 1'b1;
  end

endmodule

// File: rtl/uvr_control.sv
module uvr_control
  import uvr_pkg::*;
(
  input  logic       clk,
  input  logic       arstN,
  input  logic       uvDet,
  input  logic       uvOk,
  input  logic       forceRst,
  input  logic       detDone,
  input  logic       rcvDone,
  output cntStrobe_t strobe,
  output logic       sysRstN
);

  rstState_e state, stateNext;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) state <= ST_HOLD;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_RUN: begin
        strobe.rcvClr = 1'b1;
        if (forceRst) begin
          strobe.detClr = 1'b1;
          stateNext     = ST_HOLD;
        end else if (uvDet) begin
          if (detDone) begin
            strobe.detClr = 1'b1;
            stateNext     = ST_HOLD;
          end else begin
            strobe.detInc = 1'b1;
          end
        end else begin
          strobe.detClr = 1'b1;
        end
      end
      ST_HOLD: begin
        strobe.detClr = 1'b1;
        if (forceRst || !uvOk) begin
          strobe.rcvClr = 1'b1;
        end else if (rcvDone) begin
          strobe.rcvClr = 1'b1;
          stateNext     = ST_RUN;
        end else begin
          strobe.rcvInc = 1'b1;
        end
      end
      default: stateNext = ST_HOLD;
    endcase
  end

  assign sysRstN = (state == ST_RUN);

endmodule

// File: rtl/uvr_top.sv
module uvr_top
  import uvr_pkg::*;
#(
  parameter int DET_CYCLES = 1000,
  parameter int RCV_CYCLES = 500000,
  parameter int NUM_HS     = 3
) (
  input  logic              clk,
  input  logic              arstN,
  input  logic              uvDet,
  input  logic              uvOk,
  input  logic              forceRst,
  input  logic              overTemp,
  input  logic [NUM_HS-1:0] hsReq,
  input  logic              busOff,
  output logic              sysRstN,
  output logic [NUM_HS-1:0] hsEn,
  output logic              busClose
);

  cntStrobe_t strobe;
  logic       detDone;
  logic       rcvDone;

  uvr_control uCtl (
    .clk      (clk),
    .arstN    (arstN),
    .uvDet    (uvDet),
    .uvOk     (uvOk),
    .forceRst (forceRst),
    .detDone  (detDone),
    .rcvDone  (rcvDone),
    .strobe   (strobe),
    .sysRstN  (sysRstN)
  );

  uvr_datapath #(
    .DET_CYCLES (DET_CYCLES),
    .RCV_CYCLES (RCV_CYCLES),
    .NUM_HS     (NUM_HS)
  ) uDp (
    .clk      (clk),
    .arstN    (arstN),
    .strobe   (strobe),
    .sysRstN  (sysRstN),
    .overTemp (overTemp),
    .hsReq    (hsReq),
    .busOff   (busOff),
    .detDone  (detDone),
    .rcvDone  (rcvDone),
    .hsEn     (hsEn),
    .busClose (busClose)
  );

endmodule

// File: rtl/uvr_checker.sv
module uvr_checker #(
  parameter int DET_CYCLES = 1000,
  parameter int NUM_HS     = 3
) (
  input logic              clk,
  input logic              arstN,
  input logic              uvDet,
  input logic              uvOk,
  input logic              forceRst,
  input logic              overTemp,
  input logic [NUM_HS-1:0] hsReq,
  input logic              busOff,
  input logic              sysRstN,
  input logic [NUM_HS-1:0] hsEn,
  input logic              busClose
);

  localparam int RUN_W = $clog2(DET_CYCLES + 1);
  localparam logic [RUN_W-1:0] RUN_SAT  = RUN_W'(DET_CYCLES);
  localparam logic [RUN_W-1:0] RUN_NEED = RUN_W'(DET_CYCLES - 1);

  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)             runLen <= '0;
    else if (!uvDet)        runLen <= '0;
    else if (runLen != RUN_SAT) runLen <= runLen + 1'b1;
  end

  // R2 R3
  fall_needs_run_chk: assert property (@(posedge clk) disable iff (!arstN)
    ($fell(sysRstN) && !$past(forceRst)) |-> ($past(uvDet) && ($past(runLen) >= RUN_NEED)));

  // R4 R5
  rise_needs_ok_chk: assert property (@(posedge clk) disable iff (!arstN)
    $rose(sysRstN) |-> ($past(uvOk) && !$past(forceRst)));

  // R6
  force_low_chk: assert property (@(posedge clk) disable iff (!arstN)
    forceRst |=> !sysRstN);

  // R7
  hs_follow_chk: assert property (@(posedge clk) disable iff (!arstN)
    sysRstN |-> (hsEn == hsReq));

  // R8
  hs_gated_chk: assert property (@(posedge clk) disable iff (!arstN)
    !sysRstN |-> (hsEn == '0));

  // R9
  bus_follow_chk: assert property (@(posedge clk) disable iff (!arstN)
    (sysRstN && !overTemp) |-> (busClose == !busOff));

  // R10
  bus_default_chk: assert property (@(posedge clk) disable iff (!arstN)
    (!sysRstN || overTemp) |-> busClose);

endmodule

bind uvr_top uvr_checker #(
  .DET_CYCLES (DET_CYCLES),
  .NUM_HS     (NUM_HS)
) uChk (
  .clk      (clk),
  .arstN    (arstN),
  .uvDet    (uvDet),
  .uvOk     (uvOk),
  .forceRst (forceRst),
  .overTemp (overTemp),
  .hsReq    (hsReq),
  .busOff   (busOff),
  .sysRstN  (sysRstN),
  .hsEn     (hsEn),
  .busClose (busClose)
);

// File: tb/tb_uvr_top.sv
module tb_uvr_top;

  localparam int DET = 8;
  localparam int RCV = 40;

  logic       clk = 1'b0;
  logic       arstN;
  logic       uvDet, uvOk, forceRst, overTemp, busOff;
  logic [2:0] hsReq;
  logic       sysRstN, busClose;
  logic [2:0] hsEn;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    string      tag;
    logic       rstN;
    logic [2:0] hs;
    logic       bus;
  } exp_t;

  exp_t sbq[$];

  always #4 clk = ~clk;

  uvr_top #(.DET_CYCLES(DET), .RCV_CYCLES(RCV), .NUM_HS(3)) dut (
    .clk(clk), .arstN(arstN), .uvDet(uvDet), .uvOk(uvOk), .forceRst(forceRst),
    .overTemp(overTemp), .hsReq(hsReq), .busOff(busOff),
    .sysRstN(sysRstN), .hsEn(hsEn), .busClose(busClose)
  );

  // monitor: compare outputs against queued expectations away from the edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq[0];
      checks++;
      if (sysRstN !== e.rstN || hsEn !== e.hs || busClose !== e.bus) begin
        errors++;
        $display("FAIL %s actual rst=%b hs=%b bus=%b expected rst=%b hs=%b bus=%b",
                 e.tag, sysRstN, hsEn, busClose, e.rstN, e.hs, e.bus);
      end
      void'(sbq.pop_front());
    end
  end

  task automatic expect_out(string tag, logic r, logic [2:0] h, logic b);
    exp_t e;
    e.tag = tag; e.rstN = r; e.hs = h; e.bus = b;
    sbq.push_back(e);
    wait (sbq.size() == 0);
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    arstN = 0; uvDet = 0; uvOk = 0; forceRst = 0; overTemp = 0;
    hsReq = 3'b111; busOff = 1;
    tick(3);
    expect_out("R1 reset state", 0, 3'b000, 1);

    // release block reset, supply recovers
    arstN = 1; uvOk = 1;
    tick(RCV - 1);
    expect_out("R4 one edge short of release", 0, 3'b000, 1);
    tick(1);
    expect_out("R4 release after full window", 1, 3'b111, 0);

    // R7 / R9 patterns
    hsReq = 3'b101; busOff = 0;
    #1 expect_out("R7 R9 pattern 101 bus closed", 1, 3'b101, 1);
    hsReq = 3'b010; busOff = 1;
    #1 expect_out("R7 R9 pattern 010 bus open", 1, 3'b010, 0);
    overTemp = 1;
    #1 expect_out("R10 overtemp forces bus closed", 1, 3'b010, 1);
    overTemp = 0; hsReq = 3'b111;

    // R3 short detect pulse
    uvDet = 1;
    tick(DET - 1);
    uvDet = 0;
    tick(2);
    expect_out("R3 short pulse ignored", 1, 3'b111, 0);

    // R2 full detect window
    uvDet = 1; uvOk = 0;
    tick(DET - 1);
    expect_out("R2 one edge short of detect", 1, 3'b111, 0);
    tick(1);
    expect_out("R2 reset after detect window", 0, 3'b000, 1);
    hsReq = 3'b011; busOff = 1;
    #1 expect_out("R8 R10 inputs ignored in reset", 0, 3'b000, 1);

    // R5 recovery restart
    uvDet = 0; uvOk = 1; hsReq = 3'b111;
    tick(30);
    uvOk = 0;
    tick(1);
    uvOk = 1;
    tick(RCV - 1);
    expect_out("R5 count restarted after drop", 0, 3'b000, 1);
    tick(1);
    expect_out("R5 release after restarted window", 1, 3'b111, 0);

    // R6 forced reset
    forceRst = 1;
    tick(1);
    expect_out("R6 force pulls reset low", 0, 3'b000, 1);
    tick(50);
    expect_out("R6 force holds reset low", 0, 3'b000, 1);
    forceRst = 0;
    tick(RCV - 1);
    expect_out("R6 count starts after force drops", 0, 3'b000, 1);
    tick(1);
    expect_out("R6 release after force", 1, 3'b111, 0);

    finish_run();
  end

endmodule